// File: doc/BRIEF.md
# ADC Autoconversion Sequencer

This controller runs an external analog-to-digital converter through a programmed list of 4-bit channel codes. One start request produces a whole run of conversions. For each list entry the block drives a channel code and a sampling-mode flag, pulses a start strobe and waits for the converter's done pulse. The returned data is written into the next result slot of a 16-slot result bank. A read port gives access to that bank.

The block works in one of two arrangements. In the split arrangement there are two independent 8-entry sequencers, called lane 1 and lane 2, which share the one converter. In the joined arrangement there is a single 16-entry sequencer, and it is started from lane 1.

Each channel code has two parts. The top bit picks sample-and-hold group A (0) or group B (1), and the low three bits give the pin offset. In simultaneous sampling, both groups sample the same offset. Each step then returns a pair of results.

Top module: `adc_autoseq`

## Requirements
- R1: After reset, busy_l1, busy_l2, done_l1, done_l2 and conv_start are low, and every result slot reads zero.
- R2: A single pulse on soc_l1 or soc_l2 makes the block issue one conv_start per list entry, without further requests. The entries are taken in ascending order from the first entry of that sequencer, and the next entry is issued only after conv_done has returned for the previous one. A code may repeat across entries.
- R3: The count value v (written with cfg_cnt_sel 0 for lane 1, 1 for lane 2, 2 for joined) makes a run convert exactly v+1 entries. Lanes use only the low three bits of v. After the last conversion no further conv_start is issued.
- R4: In sequential sampling, the result of step k of a lane 1 run (or of a joined run) is written to slot k. Each write replaces the earlier value of that slot.
- R5: In the split arrangement, lane 2 takes its codes from list entries 8 to 15 and writes step k to slot 8+k.
- R6: With cascade_mode high, a lane 1 request runs list entries 0 to 15 as one sequencer. soc_l2 has no effect: busy_l2 and done_l2 stay low and no conversion is added.
- R7: A request that arrives while the converter is serving another run stays pending and is taken when that run ends. If both lanes are pending, lane 1 is taken first.
- R8: In sequential sampling (simul_mode low), conv_chan carries all four bits of the list code and conv_simul is low. Example: code 0101 selects group A pin 5, and code 1011 selects group B pin 3.
- R9: In simultaneous sampling (simul_mode high), conv_chan has its top bit forced to 0 and conv_simul is high. Step k writes conv_res_a to slot base+((2k) mod capacity) and conv_res_b to the slot above it. The base is 0, or 8 for lane 2. The capacity is 8 for a lane or 16 when joined.
- R10: Busy for the lane being served rises in the cycle after the request is accepted and stays high until the last result is written. A one-cycle done pulse for that lane follows in the next cycle, with busy already low.
- R11: A sync_clr pulse aborts any run, drops all pending requests and returns the step and result pointers to the first entry. Busy is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_clr | input | 1 | Synchronous abort and pointer clear |
| cascade_mode | input | 1 | 1 = one 16-entry sequencer, 0 = two 8-entry lanes |
| simul_mode | input | 1 | 1 = simultaneous sampling, 0 = sequential |
| soc_l1 | input | 1 | Start request for lane 1 (or the joined sequencer) |
| soc_l2 | input | 1 | Start request for lane 2 |
| cfg_chan_we | input | 1 | Write enable for a list entry |
| cfg_chan_idx | input | 4 | List entry index |
| cfg_chan_code | input | 4 | Channel code to store |
| cfg_cnt_we | input | 1 | Write enable for a count value |
| cfg_cnt_sel | input | 2 | Count target: 0 lane 1, 1 lane 2, 2 joined |
| cfg_cnt_val | input | 4 | Entries per run minus one |
| conv_start | output | 1 | One-cycle strobe that starts a conversion |
| conv_chan | output | 4 | Channel code for the current conversion |
| conv_simul | output | 1 | Simultaneous sampling flag for the converter |
| conv_done | input | 1 | Conversion finished, results valid |
| conv_res_a | input | 12 | Result from group A, or the single result |
| conv_res_b | input | 12 | Result from group B in simultaneous sampling |
| busy_l1 | output | 1 | Lane 1 run in progress |
| busy_l2 | output | 1 | Lane 2 run in progress |
| done_l1 | output | 1 | Lane 1 run finished (one cycle) |
| done_l2 | output | 1 | Lane 2 run finished (one cycle) |
| rd_slot | input | 4 | Result slot to read |
| rd_data | output | 12 | Content of the selected result slot |

## Verification
The list holds distinct codes per lane, with repeats inside lane 1. A wrong entry index, a wrong base or a failure to oversample each therefore shows up as a wrong conv_chan or a wrong stored value.

The block is exercised with the following patterns, each aimed at a different possible fault:
- A short lane 1 run and a full lane 2 run test the count limit and the base offsets.
- Back-to-back requests, arriving from both lanes while lane 2 is busy, show whether pending requests are kept and whether lane 1 wins.
- A simultaneous run whose step count passes the lane capacity checks the pair slots and their wrap.
- A joined run with a stray lane 2 request checks the 16-entry path.
- An abort that lands mid-run, with a lane 2 request pending, checks that a later run restarts at entry 0.

// File: rtl/adc_autoseq_pkg.sv
package adc_autoseq_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for a pending request
        ST_ISSUE = 2'd1,   // start strobe for the current entry
        ST_WAIT  = 2'd2,   // waiting for the converter result
        ST_DONE  = 2'd3    // end-of-run pulse
    } seq_state_e;

    // Which lane owns the current run
    typedef enum logic {
        LANE1 = 1'b0,
        LANE2 = 1'b1
    } seq_owner_e;

    // Count register targets
    localparam logic [1:0] CNT_SEL_L1  = 2'd0;
    localparam logic [1:0] CNT_SEL_L2  = 2'd1;
    localparam logic [1:0] CNT_SEL_CAS = 2'd2;

endpackage

// File: rtl/autoseq_req_arb.sv
module autoseq_req_arb
    import adc_autoseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       cascade,
    input  logic       soc_l1,
    input  logic       soc_l2,
    input  logic       take,
    output logic       grant_vld,
    output seq_owner_e grant_owner
);

    logic pend1_q;
    logic pend2_q;
    logic take1;
    logic take2;

    assign take1 = take && (grant_owner == LANE1);
    assign take2 = take && (grant_owner == LANE2);

    // A new pulse wins over the clear caused by acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend1_q <= 1'b0;
            pend2_q <= 1'b0;
        end else if (clr) begin
            pend1_q <= 1'b0;
            pend2_q <= 1'b0;
        end else begin
            pend1_q <= soc_l1 || (pend1_q && !take1);
            pend2_q <= !cascade && (soc_l2 || (pend2_q && !take2));
        end
    end

    // Fixed priority: lane 1 first
    assign grant_vld   = pend1_q || pend2_q;
    assign grant_owner = pend1_q ? LANE1 : LANE2;

endmodule

// File: rtl/autoseq_chan_table.sv
module autoseq_chan_table #(
    parameter int DEPTH  = 16,
    parameter int CODE_W = 4,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CODE_W-1:0] rd_code
);

    logic [CODE_W-1:0] ent_q [DEPTH];
    logic [DEPTH-1:0]  hit;

    // One write-select line per entry
    for (genvar g = 0; g < DEPTH; g++) begin : g_sel
        assign hit[g] = we && (wr_idx == IDX_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (hit[i]) ent_q[i] <= wr_code;
            end
        end
    end

    assign rd_code = ent_q[rd_idx];

endmodule

// File: rtl/autoseq_result_bank.sv
module autoseq_result_bank #(
    parameter int DEPTH = 16,
    parameter int RES_W = 12,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_a,
    input  logic [IDX_W-1:0] idx_a,
    input  logic [RES_W-1:0] data_a,
    input  logic             we_b,
    input  logic [IDX_W-1:0] idx_b,
    input  logic [RES_W-1:0] data_b,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [RES_W-1:0] rd_data
);

    logic [RES_W-1:0] slot_q [DEPTH];
    logic [DEPTH-1:0] hit_a;
    logic [DEPTH-1:0] hit_b;

    for (genvar g = 0; g < DEPTH; g++) begin : g_dec
        assign hit_a[g] = we_a && (idx_a == IDX_W'(g));
        assign hit_b[g] = we_b && (idx_b == IDX_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (hit_b[i])      slot_q[i] <= data_b;
                else if (hit_a[i]) slot_q[i] <= data_a;
            end
        end
    end

    assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/adc_autoseq.sv
module adc_autoseq
    import adc_autoseq_pkg::*;
#(
    parameter int HALF_DEPTH = 8,
    parameter int CODE_W     = 4,
    parameter int RES_W      = 12,
    localparam int DEPTH     = 2 * HALF_DEPTH,
    localparam int IDX_W     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_clr,
    input  logic              cascade_mode,
    input  logic              simul_mode,
    input  logic              soc_l1,
    input  logic              soc_l2,
    input  logic              cfg_chan_we,
    input  logic [IDX_W-1:0]  cfg_chan_idx,
    input  logic [CODE_W-1:0] cfg_chan_code,
    input  logic              cfg_cnt_we,
    input  logic [1:0]        cfg_cnt_sel,
    input  logic [IDX_W-1:0]  cfg_cnt_val,
    output logic              conv_start,
    output logic [CODE_W-1:0] conv_chan,
    output logic              conv_simul,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_res_a,
    input  logic [RES_W-1:0]  conv_res_b,
    output logic              busy_l1,
    output logic              busy_l2,
    output logic              done_l1,
    output logic              done_l2,
    input  logic [IDX_W-1:0]  rd_slot,
    output logic [RES_W-1:0]  rd_data
);

    localparam logic [IDX_W-1:0] HALF_MASK = IDX_W'(HALF_DEPTH - 1);
    localparam logic [IDX_W-1:0] FULL_MASK = IDX_W'(DEPTH - 1);
    localparam logic [IDX_W-1:0] HALF_BASE = IDX_W'(HALF_DEPTH);

    seq_state_e        state_q;
    seq_state_e        state_d;
    seq_owner_e        owner_q;
    seq_owner_e        grant_owner;
    logic              grant_vld;
    logic              take;
    logic              wr_fire;
    logic              last_hit;
    logic              busy_any;
    logic [IDX_W-1:0]  step_q;
    logic [IDX_W-1:0]  last_step;
    logic [IDX_W-1:0]  base_idx;
    logic [IDX_W-1:0]  slot_mask;
    logic [IDX_W-1:0]  entry_idx;
    logic [IDX_W-1:0]  slot_a;
    logic [IDX_W-1:0]  slot_b;
    logic [IDX_W-1:0]  cnt_l1_q;
    logic [IDX_W-1:0]  cnt_l2_q;
    logic [IDX_W-1:0]  cnt_cas_q;
    logic [CODE_W-1:0] list_code;

    // ---------------- request latch and priority ----------------
    autoseq_req_arb u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (sync_clr),
        .cascade     (cascade_mode),
        .soc_l1      (soc_l1),
        .soc_l2      (soc_l2),
        .take        (take),
        .grant_vld   (grant_vld),
        .grant_owner (grant_owner)
    );

    // ---------------- count registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_l1_q  <= '0;
            cnt_l2_q  <= '0;
            cnt_cas_q <= '0;
        end else if (cfg_cnt_we) begin
            unique case (cfg_cnt_sel)
                CNT_SEL_L1:  cnt_l1_q  <= cfg_cnt_val & HALF_MASK;
                CNT_SEL_L2:  cnt_l2_q  <= cfg_cnt_val & HALF_MASK;
                CNT_SEL_CAS: cnt_cas_q <= cfg_cnt_val;
                default:     ;
            endcase
        end
    end

    // ---------------- address generation ----------------
    always_comb begin
        if (cascade_mode) begin
            base_idx  = '0;
            slot_mask = FULL_MASK;
            last_step = cnt_cas_q;
        end else if (owner_q == LANE2) begin
            base_idx  = HALF_BASE;
            slot_mask = HALF_MASK;
            last_step = cnt_l2_q;
        end else begin
            base_idx  = '0;
            slot_mask = HALF_MASK;
            last_step = cnt_l1_q;
        end
        entry_idx = base_idx | (step_q & slot_mask);
        if (simul_mode) slot_a = base_idx | ((step_q << 1) & slot_mask);
        else            slot_a = base_idx | (step_q & slot_mask);
        slot_b   = slot_a | IDX_W'(1);
        last_hit = (step_q == last_step);
    end

    // ---------------- channel list ----------------
    autoseq_chan_table #(
        .DEPTH  (DEPTH),
        .CODE_W (CODE_W),
        .IDX_W  (IDX_W)
    ) u_list (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_chan_we),
        .wr_idx  (cfg_chan_idx),
        .wr_code (cfg_chan_code),
        .rd_idx  (entry_idx),
        .rd_code (list_code)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        if (sync_clr) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (grant_vld) state_d = ST_ISSUE;
                ST_ISSUE: state_d = ST_WAIT;
                ST_WAIT:  if (conv_done) state_d = last_hit ? ST_DONE : ST_ISSUE;
                ST_DONE:  state_d = ST_IDLE;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        conv_start = 1'b0;
        busy_any   = 1'b0;
        done_l1    = 1'b0;
        done_l2    = 1'b0;
        wr_fire    = 1'b0;
        take       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                take = grant_vld && !sync_clr;
            end
            ST_ISSUE: begin
                conv_start = 1'b1;
                busy_any   = 1'b1;
            end
            ST_WAIT: begin
                busy_any = 1'b1;
                wr_fire  = conv_done && !sync_clr;
            end
            ST_DONE: begin
                done_l1 = (owner_q == LANE1);
                done_l2 = (owner_q == LANE2);
            end
        endcase
        busy_l1    = busy_any && (owner_q == LANE1);
        busy_l2    = busy_any && (owner_q == LANE2);
        conv_simul = simul_mode;
        if (simul_mode) conv_chan = {1'b0, list_code[CODE_W-2:0]};
        else            conv_chan = list_code;
    end

    // ---------------- step pointer and owner ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q  <= '0;
            owner_q <= LANE1;
        end else if (sync_clr || state_q == ST_DONE) begin
            step_q <= '0;
        end else if (take) begin
            step_q  <= '0;
            owner_q <= grant_owner;
        end else if (wr_fire && !last_hit) begin
            step_q <= step_q + IDX_W'(1);
        end
    end

    // ---------------- result storage ----------------
    autoseq_result_bank #(
        .DEPTH (DEPTH),
        .RES_W (RES_W),
        .IDX_W (IDX_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_a    (wr_fire),
        .idx_a   (slot_a),
        .data_a  (conv_res_a),
        .we_b    (wr_fire && simul_mode),
        .idx_b   (slot_b),
        .data_b  (conv_res_b),
        .rd_idx  (rd_slot),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/autoseq_checker.sv
module autoseq_checker (
    input logic clk,
    input logic rst_n,
    input logic sync_clr,
    input logic cascade_mode,
    input logic conv_start,
    input logic chan_top,
    input logic conv_simul,
    input logic busy_l1,
    input logic busy_l2,
    input logic done_l1,
    input logic done_l2
);

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R2

    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (busy_l1 || busy_l2)); // R10

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_l1 && busy_l2)); // R7

    AST_DONE1_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_l1 |=> !done_l1); // R3

    AST_DONE2_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_l2 |=> !done_l2); // R3

    AST_DONE1_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_l1 |-> ($past(busy_l1) && !busy_l1)); // R10

    AST_DONE2_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_l2 |-> ($past(busy_l2) && !busy_l2)); // R10

    AST_JOINED_LANE2_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_mode |-> (!busy_l2 && !done_l2)); // R6

    AST_PAIR_TOPBIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && conv_simul) |-> !chan_top); // R9

    AST_CLEAR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr |=> (!busy_l1 && !busy_l2)); // R11

endmodule

bind adc_autoseq autoseq_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_clr     (sync_clr),
    .cascade_mode (cascade_mode),
    .conv_start   (conv_start),
    .chan_top     (conv_chan[CODE_W-1]),
    .conv_simul   (conv_simul),
    .busy_l1      (busy_l1),
    .busy_l2      (busy_l2),
    .done_l1      (done_l1),
    .done_l2      (done_l2)
);

// File: tb/sim_adc_autoseq.sv
`timescale 1ns/1ps
module sim_adc_autoseq;

    localparam int IDX_W  = 4;
    localparam int CODE_W = 4;
    localparam int RES_W  = 12;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n, sync_clr, cascade_mode, simul_mode;
    logic              soc_l1, soc_l2;
    logic              cfg_chan_we, cfg_cnt_we;
    logic [IDX_W-1:0]  cfg_chan_idx, cfg_cnt_val, rd_slot;
    logic [CODE_W-1:0] cfg_chan_code;
    logic [1:0]        cfg_cnt_sel;
    logic              conv_start, conv_simul, conv_done;
    logic [CODE_W-1:0] conv_chan;
    logic [RES_W-1:0]  conv_res_a, conv_res_b, rd_data;
    logic              busy_l1, busy_l2, done_l1, done_l2;

    adc_autoseq u0 (.*);

    int tests = 0;
    int fails = 0;
    int exp_k = 0;
    int conv_k = 0;
    int done1_cnt = 0;
    int done2_cnt = 0;
    bit prev_d1 = 0, prev_d2 = 0, prev_b1 = 0, prev_b2 = 0;
    bit finished = 0;

    logic [5:0]        exp_q[$];       // {lane2, simul, code}
    logic [RES_W-1:0]  exp_bank [16];
    logic [CODE_W-1:0] tb_chan [16];
    int                tb_cnt [3];

    task automatic report_fail(string req, string what, int act, int expv);
        fails++;
        $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    endtask

    task automatic check(string req, string what, int act, int expv);
        tests++;
        if (act != expv) report_fail(req, what, act, expv);
    endtask

    // ---------------- driver side ----------------
    task automatic queue_seq(input int lane);
        int n, base, mask;
        logic [CODE_W-1:0] code, dcode;
        n    = cascade_mode ? tb_cnt[2] + 1 : tb_cnt[lane-1] + 1;
        base = (!cascade_mode && lane == 2) ? 8 : 0;
        mask = cascade_mode ? 15 : 7;
        for (int s = 0; s < n; s++) begin
            code  = tb_chan[base + s];
            dcode = simul_mode ? {1'b0, code[2:0]} : code;
            exp_q.push_back({lane == 2, simul_mode, dcode});
            if (simul_mode) begin
                exp_bank[base | ((2*s) & mask)]     = {1'b0, code[2:0], 8'(exp_k)};
                exp_bank[(base | ((2*s) & mask)) | 1] = {1'b1, code[2:0], 8'(exp_k)};
            end else begin
                exp_bank[base | s] = {dcode, 8'(exp_k)};
            end
            exp_k++;
        end
    endtask

    task automatic pulse_soc(input bit a, input bit b);
        soc_l1 = a;
        soc_l2 = b;
        @(negedge clk);
        soc_l1 = 1'b0;
        soc_l2 = 1'b0;
    endtask

    task automatic write_chan(input int idx, input logic [CODE_W-1:0] code);
        cfg_chan_we = 1'b1; cfg_chan_idx = IDX_W'(idx); cfg_chan_code = code;
        tb_chan[idx] = code;
        @(negedge clk);
        cfg_chan_we = 1'b0;
    endtask

    task automatic write_cnt(input int sel, input int val);
        cfg_cnt_we = 1'b1; cfg_cnt_sel = 2'(sel); cfg_cnt_val = IDX_W'(val);
        tb_cnt[sel] = (sel == 2) ? val : (val & 7);
        @(negedge clk);
        cfg_cnt_we = 1'b0;
    endtask

    task automatic wait_done(input int t1, input int t2, input string req);
        while (done1_cnt < t1 || done2_cnt < t2) @(negedge clk);
        repeat (6) @(negedge clk);
        check(req, "leftover expected conversions", exp_q.size(), 0);
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < 16; i++) begin
            rd_slot = IDX_W'(i);
            #1;
            check(req, $sformatf("result slot %0d", i), int'(rd_data), int'(exp_bank[i]));
        end
    endtask

    // ---------------- converter model and start monitor ----------------
    initial begin
        conv_done  = 1'b0;
        conv_res_a = '0;
        conv_res_b = '0;
        forever begin
            if (rst_n === 1'b1 && conv_start === 1'b1) begin
                logic [5:0] item;
                if (exp_q.size() == 0) begin
                    tests++;
                    report_fail("R3", "unexpected conversion start, chan", int'(conv_chan), 0);
                end else begin
                    item = exp_q.pop_front();
                    check("R2/R8", "conv_chan", int'(conv_chan), int'(item[3:0]));
                    check("R9", "conv_simul", int'(conv_simul), int'(item[4]));
                    check("R7", "owning lane busy", int'(item[5] ? busy_l2 : busy_l1), 1);
                end
                if (conv_simul) begin
                    conv_res_a = {1'b0, conv_chan[2:0], 8'(conv_k)};
                    conv_res_b = {1'b1, conv_chan[2:0], 8'(conv_k)};
                end else begin
                    conv_res_a = {conv_chan, 8'(conv_k)};
                    conv_res_b = '0;
                end
                conv_k++;
                repeat (3) @(negedge clk);
                conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    // ---------------- done/busy monitor ----------------
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1) begin
                if (done_l1) begin
                    tests++;
                    if (prev_d1 || !prev_b1 || busy_l1)
                        report_fail("R10", "lane 1 done/busy shape", {prev_d1, prev_b1, busy_l1}, 3'b010);
                    if (!prev_d1) done1_cnt++;
                end
                if (done_l2) begin
                    tests++;
                    if (prev_d2 || !prev_b2 || busy_l2)
                        report_fail("R10", "lane 2 done/busy shape", {prev_d2, prev_b2, busy_l2}, 3'b010);
                    if (!prev_d2) done2_cnt++;
                end
            end
            prev_d1 = done_l1; prev_d2 = done_l2;
            prev_b1 = busy_l1; prev_b2 = busy_l2;
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++;
            report_fail("ALL", "watchdog expired", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int d1, d2;
        rst_n = 1'b0; sync_clr = 1'b0; cascade_mode = 1'b0; simul_mode = 1'b0;
        soc_l1 = 1'b0; soc_l2 = 1'b0; cfg_chan_we = 1'b0; cfg_cnt_we = 1'b0;
        cfg_chan_idx = '0; cfg_chan_code = '0; cfg_cnt_sel = '0; cfg_cnt_val = '0;
        rd_slot = '0;
        for (int i = 0; i < 16; i++) begin exp_bank[i] = '0; tb_chan[i] = '0; end
        for (int i = 0; i < 3; i++) tb_cnt[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1", "busy_l1", int'(busy_l1), 0);
        check("R1", "busy_l2", int'(busy_l2), 0);
        check("R1", "done_l1/done_l2", int'({done_l1, done_l2}), 0);
        check("R1", "conv_start", int'(conv_start), 0);
        check_bank("R1");

        // program the list: lane 1 has repeats (oversampling), lane 2 distinct
        write_chan(0, 4'b0101); write_chan(1, 4'b1011); write_chan(2, 4'd3);
        write_chan(3, 4'd3);    write_chan(4, 4'd3);    write_chan(5, 4'd14);
        write_chan(6, 4'd0);    write_chan(7, 4'd9);
        write_chan(8, 4'd7);    write_chan(9, 4'd12);   write_chan(10, 4'd1);
        write_chan(11, 4'd15);  write_chan(12, 4'd6);   write_chan(13, 4'd2);
        write_chan(14, 4'd10);  write_chan(15, 4'd4);
        write_cnt(0, 3); write_cnt(1, 7); write_cnt(2, 15);

        // R2 R3 R4 R8: short lane 1 run, sequential
        d1 = done1_cnt; d2 = done2_cnt;
        queue_seq(1);
        pulse_soc(1'b1, 1'b0);
        wait_done(d1 + 1, d2, "R3");
        check_bank("R4");

        // R5: full lane 2 run
        d1 = done1_cnt; d2 = done2_cnt;
        queue_seq(2);
        pulse_soc(1'b0, 1'b1);
        wait_done(d1, d2 + 1, "R5");
        check_bank("R5");

        // R7: both lanes request while lane 2 is busy; lane 1 must go next
        write_cnt(1, 2);
        d1 = done1_cnt; d2 = done2_cnt;
        queue_seq(2);
        pulse_soc(1'b0, 1'b1);
        repeat (2) @(negedge clk);
        queue_seq(1);
        queue_seq(2);
        pulse_soc(1'b1, 1'b1);
        wait_done(d1 + 1, d2 + 2, "R7");
        check("R7", "lane 1 runs", done1_cnt - d1, 1);
        check("R7", "lane 2 runs", done2_cnt - d2, 2);
        check_bank("R7");

        // R9: simultaneous pairs on lane 2, count past capacity/2 wraps
        simul_mode = 1'b1;
        write_cnt(1, 4);
        d1 = done1_cnt; d2 = done2_cnt;
        queue_seq(2);
        pulse_soc(1'b0, 1'b1);
        wait_done(d1, d2 + 1, "R9");
        check_bank("R9");
        simul_mode = 1'b0;

        // R6: joined 16-entry run, lane 2 request ignored
        cascade_mode = 1'b1;
        @(negedge clk);
        d1 = done1_cnt; d2 = done2_cnt;
        queue_seq(1);
        pulse_soc(1'b1, 1'b0);
        repeat (3) @(negedge clk);
        pulse_soc(1'b0, 1'b1);
        wait_done(d1 + 1, d2, "R6");
        check("R6", "lane 2 done count", done2_cnt - d2, 0);
        check("R6", "busy_l2", int'(busy_l2), 0);
        check_bank("R6");
        cascade_mode = 1'b0;
        @(negedge clk);

        // R11: abort mid-run with a lane 2 request pending
        write_cnt(0, 7);
        d1 = done1_cnt; d2 = done2_cnt;
        queue_seq(1);
        pulse_soc(1'b1, 1'b0);
        repeat (8) @(negedge clk);
        pulse_soc(1'b0, 1'b1);
        sync_clr = 1'b1;
        @(negedge clk);
        sync_clr = 1'b0;
        check("R11", "busy after clear", int'({busy_l1, busy_l2}), 0);
        exp_q.delete();
        repeat (12) @(negedge clk);
        check("R11", "dropped lane 2 request runs", done2_cnt - d2, 0);
        check("R11", "aborted run done pulses", done1_cnt - d1, 0);
        check("R11", "busy while idle", int'({busy_l1, busy_l2}), 0);
        exp_k = conv_k;
        d1 = done1_cnt;
        queue_seq(1);
        pulse_soc(1'b1, 1'b0);
        wait_done(d1 + 1, d2, "R11");
        check_bank("R11");

        check("R3", "final queue empty", exp_q.size(), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule